// File: doc/BRIEF.md
# Triangular/Sawtooth PWM Carrier Timer

This block is a 16-bit carrier counter for multi-channel pulse-width modulation. One counter serves three waveform modes. Two modes count up and down to form a triangle. The third counts up only to form a sawtooth. A period register sets the turn-around or clear point. Three duty registers set where each PWM output switches.

Software never writes the live compare registers directly. It writes shadow (buffer) copies at any time. The block copies them into the live registers at points that depend on the mode: at the valley only (symmetric triangle), at the valley and the peak (asymmetric triangle), or at the clear point (sawtooth). A prescaler divides the base clock by a power of two from 1 to 32. A run enable stops the counter and holds it at zero.

The block drives two single-clock event pulses, one at the valley and one at the peak or clear point, for an interrupt controller outside this block. Any masking done in that controller has no effect on counting or on buffer transfers.

Top module: `pwm_carrier_timer`

## Requirements
- R1: After reset, `count` is 0, `ev_bound` and `ev_peak` are 0, and every `pwm` bit is 0.
- R2: While `run` is 0, `count` is 0 on the next clock and the live compare registers copy their buffers on every clock. When `run` rises, counting starts at 0 going up, using the buffered values.
- R3: `count` changes once every 2^`psc_sel` clocks. A value of 6 or 7 is treated as 5. With prescaler value s, the first change comes on clock edge 2^s after `run` is seen high.
- R4: In modes 0 and 1 (`mode` = 2'b00 or 2'b01), the count runs 0,1,…,P,P−1,…,1,0,1,…, where P is the live period. The values P and 0 each last exactly one count step.
- R5: In modes 2 and 3 (`mode[1]` = 1), the count runs 0,1,…,P and then 0 on the next step.
- R6: In triangular modes, `ev_peak` pulses for one clock in the cycle where `count` first shows P. It never pulses together with `ev_bound`.
- R7: In triangular modes, `ev_bound` pulses for one clock in the cycle where `count` reaches 0 while counting down. In sawtooth mode, `ev_bound` never pulses.
- R8: In sawtooth mode, `ev_peak` pulses for one clock in the cycle where `count` has just cleared from P to 0.
- R9: `pwm[i]` is 1 while `count` is below live duty value i, and 0 otherwise. It follows `count` in the same cycle.
- R10: In mode 0, buffer writes (`per_wr`, `duty_wr[i]`) change only the buffers. The live registers take the buffered values only at the `ev_bound` point.
- R11: In mode 1, the live registers take the buffered values at both the `ev_bound` point and the `ev_peak` point.
- R12: In sawtooth mode, the live registers take the buffered values at the clear point. A new period is used from the next cycle onward.
- R13: In sawtooth mode with period 16'hFFFF, the count reaches 16'hFFFF and then returns to 0, with `ev_peak` pulsing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Count enable; 0 holds the count at zero |
| mode | input | 2 | 00 symmetric triangle, 01 asymmetric triangle, 1x sawtooth |
| psc_sel | input | 3 | Prescaler exponent; count clock = clk / 2^psc_sel, capped at 5 |
| per_wr | input | 1 | Write strobe for the period buffer |
| per_wdata | input | 16 | Period buffer write data |
| duty_wr | input | 3 | Per-channel write strobes for the duty buffers |
| duty_wdata | input | 16 | Duty buffer write data, shared by all channels |
| count | output | 16 | Current carrier count |
| ev_bound | output | 1 | One-clock pulse when the triangle reaches its valley |
| ev_peak | output | 1 | One-clock pulse at the triangle peak or the sawtooth clear |
| pwm | output | 3 | Per-channel PWM outputs |

## Verification
The carrier is checked with a vector walk over each mode. Each vector samples the count at chosen points in the cycle: rising, at the peak, falling and at the valley. The sawtooth samples fall before and after the wrap, so an error in the turn-around, the one-step hold at the extremes or the clear point shows up as a wrong count. Several prescaler exponents are used, including one above the cap, to tell correct tick spacing from off-by-one spacing.

A duty change is written mid-cycle in each mode and observed on the falling half or after the clear. This separates valley-only, valley-and-peak and clear-point transfers. A period change in sawtooth mode and a full 16-bit wrap exercise the clear and overflow paths.

// File: rtl/pwm_carrier_timer.sv
module pwm_carrier_timer #(
  parameter int W    = 16,
  parameter int CH   = 3,
  parameter int DIVW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [1:0]    mode,
  input  logic [2:0]    psc_sel,
  input  logic          per_wr,
  input  logic [W-1:0]  per_wdata,
  input  logic [CH-1:0] duty_wr,
  input  logic [W-1:0]  duty_wdata,
  output logic [W-1:0]  count,
  output logic          ev_bound,
  output logic          ev_peak,
  output logic [CH-1:0] pwm
);

  logic [W-1:0]    per_buf, per_act;
  logic [W-1:0]    duty_buf [CH];
  logic [W-1:0]    duty_act [CH];
  logic            up;
  logic [DIVW-1:0] div;

  logic [2:0]      sel_c;
  logic [DIVW:0]   one_hot;
  logic [DIVW-1:0] mask;
  logic            tick, saw;

  assign sel_c   = (psc_sel > 3'(DIVW)) ? 3'(DIVW) : psc_sel;
  assign one_hot = (DIVW+1)'(1) << sel_c;
  assign mask    = one_hot[DIVW-1:0] - DIVW'(1);
  assign tick    = run && ((div & mask) == mask);
  assign saw     = mode[1];

  logic [W-1:0] nxt;
  logic         nup, bnd, pk, load;

  always_comb begin
    nxt = count;
    nup = up;
    bnd = 1'b0;
    pk  = 1'b0;
    if (saw) begin
      if (count >= per_act) begin
        nxt = '0;
        pk  = 1'b1;
      end else begin
        nxt = count + W'(1);
      end
    end else if (up) begin
      if (count >= per_act) begin
        nup = 1'b0;
        nxt = (count == '0) ? '0 : count - W'(1);
      end else begin
        nxt = count + W'(1);
        pk  = (nxt == per_act);
      end
    end else begin
      if (count == '0) begin
        nup = 1'b1;
        nxt = (per_act == '0) ? '0 : W'(1);
        pk  = (per_act == W'(1));
      end else if (count == W'(1)) begin
        nxt = '0;
        bnd = 1'b1;
      end else begin
        nxt = count - W'(1);
      end
    end
  end

  always_comb begin
    if (saw)               load = pk;
    else if (mode[0])      load = bnd | pk;
    else                   load = bnd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      up       <= 1'b1;
      div      <= '0;
      ev_bound <= 1'b0;
      ev_peak  <= 1'b0;
      per_buf  <= '0;
      per_act  <= '0;
      for (int i = 0; i < CH; i++) begin
        duty_buf[i] <= '0;
        duty_act[i] <= '0;
      end
    end else begin
      if (per_wr) per_buf <= per_wdata;
      for (int i = 0; i < CH; i++)
        if (duty_wr[i]) duty_buf[i] <= duty_wdata;
      ev_bound <= 1'b0;
      ev_peak  <= 1'b0;
      if (!run) begin
        count   <= '0;
        up      <= 1'b1;
        div     <= '0;
        per_act <= per_buf;
        for (int i = 0; i < CH; i++) duty_act[i] <= duty_buf[i];
      end else begin
        div <= div + DIVW'(1);
        if (tick) begin
          count    <= nxt;
          up       <= nup;
          ev_bound <= bnd;
          ev_peak  <= pk;
          if (load) begin
            per_act <= per_buf;
            for (int i = 0; i < CH; i++) duty_act[i] <= duty_buf[i];
          end
        end
      end
    end
  end

  for (genvar g = 0; g < CH; g++) begin : g_pwm
    assign pwm[g] = (count < duty_act[g]);
  end

endmodule

// File: rtl/check_pwm_carrier_timer.sv
module check_pwm_carrier_timer #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run,
  input logic [1:0]   mode,
  input logic [W-1:0] count,
  input logic         ev_bound,
  input logic         ev_peak
);

  assert_stop_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (count == '0));

  assert_unit_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && count != $past(count)) |->
      (count == $past(count) + W'(1) || count == $past(count) - W'(1) || count == '0));

  assert_events_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_bound && ev_peak));

  assert_peak_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_peak && !mode[1] && $stable(mode)) |-> (count != '0));

  assert_bound_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bound |-> (count == '0));

  assert_saw_no_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] && $stable(mode)) |-> !ev_bound);

endmodule

bind pwm_carrier_timer check_pwm_carrier_timer #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .mode(mode),
  .count(count), .ev_bound(ev_bound), .ev_peak(ev_peak)
);

// File: tb/test_pwm_carrier_timer.sv
module test_pwm_carrier_timer;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;
  localparam int T_MODE [NV] = '{0,0,0,0,0,1,2,2,2,0,2,2,2};
  localparam int T_SEL  [NV] = '{0,0,0,0,0,0,0,0,0,2,5,1,6};
  localparam int T_PER  [NV] = '{5,5,5,5,5,4,4,4,4,5,3,6,3};
  localparam int T_DUTY [NV] = '{3,3,3,3,3,3,3,3,3,3,1,5,1};
  localparam int T_N    [NV] = '{3,5,7,10,12,6,4,5,7,13,128,9,64};
  localparam int T_EXP  [NV] = '{3,5,3,0,2,2,4,0,2,3,0,4,2};

  logic        clk = 0, rst_n = 0, run = 0, per_wr = 0;
  logic [1:0]  mode = 0;
  logic [2:0]  psc_sel = 0, duty_wr = 0;
  logic [15:0] per_wdata = 0, duty_wdata = 0, count;
  logic        ev_bound, ev_peak;
  logic [2:0]  pwm;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_carrier_timer i_pwm_carrier_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .mode(mode), .psc_sel(psc_sel),
    .per_wr(per_wr), .per_wdata(per_wdata), .duty_wr(duty_wr), .duty_wdata(duty_wdata),
    .count(count), .ev_bound(ev_bound), .ev_peak(ev_peak), .pwm(pwm)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic adv(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start(input int m, input int s, input int p, input int d0, input int d1, input int d2);
    @(negedge clk);
    run = 0; mode = 2'(m); psc_sel = 3'(s);
    per_wr = 1; per_wdata = 16'(p);
    @(negedge clk); per_wr = 0; duty_wr = 3'b001; duty_wdata = 16'(d0);
    @(negedge clk); duty_wr = 3'b010; duty_wdata = 16'(d1);
    @(negedge clk); duty_wr = 3'b100; duty_wdata = 16'(d2);
    @(negedge clk); duty_wr = 0;
    @(negedge clk); run = 1;
  endtask

  task automatic wr_duty0(input int v);
    duty_wr = 3'b001; duty_wdata = 16'(v);
    adv(1);
    duty_wr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    adv(2);
    // R1 reset state
    chk("R1 count", 32'(count), 0);
    chk("R1 events", {30'd0, ev_bound, ev_peak}, 0);
    chk("R1 pwm", 32'(pwm), 0);
    rst_n = 1;
    adv(2);

    // R3 R4 R5 R9 vector walk
    for (int k = 0; k < NV; k++) begin
      int c;
      start(T_MODE[k], T_SEL[k], T_PER[k], T_DUTY[k], T_DUTY[k] + 2, 0);
      adv(T_N[k]);
      c = T_EXP[k];
      chk($sformatf("R3 R4 R5 count vector %0d", k), 32'(count), 32'(c));
      chk($sformatf("R9 pwm vector %0d", k), 32'(pwm),
          {29'd0, 1'b0, c < T_DUTY[k] + 2, c < T_DUTY[k]});
    end

    // R2 stop clears and restart from zero
    start(0, 0, 9, 4, 4, 4);
    adv(5);
    run = 0;
    adv(1);
    chk("R2 cleared on stop", 32'(count), 0);
    adv(3);
    chk("R2 held while stopped", 32'(count), 0);
    run = 1;
    adv(2);
    chk("R2 restart counts up", 32'(count), 2);

    // R6 R7 triangular events
    start(0, 0, 3, 1, 1, 1);
    adv(3);
    chk("R6 peak pulse", {30'd0, ev_bound, ev_peak}, 32'b01);
    adv(1);
    chk("R6 peak one clock", {30'd0, ev_bound, ev_peak}, 0);
    adv(2);
    chk("R7 valley pulse", {ev_bound, ev_peak, count}, {2'b10, 16'd0});

    // R7 R8 sawtooth events
    start(2, 0, 3, 1, 1, 1);
    adv(4);
    chk("R8 clear pulse", {ev_bound, ev_peak, count}, {2'b01, 16'd0});
    begin
      logic seen = 0;
      for (int k = 0; k < 8; k++) begin
        adv(1);
        seen |= ev_bound;
      end
      chk("R7 no valley event in sawtooth", 32'(seen), 0);
    end

    // R10 mode 0: transfer only at valley
    start(0, 0, 7, 4, 0, 0);
    adv(2); wr_duty0(1);
    chk("R10 old duty rising", 32'(pwm[0]), 1);
    adv(9);
    chk("R10 old duty falling", {pwm[0], count}, {1'b1, 16'd2});
    adv(4);
    chk("R10 new duty after valley", {pwm[0], count}, {1'b0, 16'd2});

    // R11 mode 1: transfer at peak too
    start(1, 0, 7, 4, 0, 0);
    adv(2); wr_duty0(1);
    chk("R11 old duty rising", 32'(pwm[0]), 1);
    adv(9);
    chk("R11 new duty after peak", {pwm[0], count}, {1'b0, 16'd2});

    // R12 mode 2: transfer at clear, duty and period
    start(2, 0, 7, 4, 0, 0);
    adv(2); wr_duty0(1);
    chk("R12 old duty before clear", {pwm[0], count}, {1'b1, 16'd3});
    adv(7);
    chk("R12 new duty after clear", {pwm[0], count}, {1'b0, 16'd2});
    start(2, 0, 5, 0, 0, 0);
    per_wr = 1; per_wdata = 16'd2;
    adv(1); per_wr = 0;
    adv(4);
    chk("R12 old period still used", 32'(count), 5);
    adv(3);
    chk("R12 new period peak", 32'(count), 2);
    adv(1);
    chk("R12 new period clear", 32'(count), 0);

    // R13 full-width wrap
    start(2, 0, 16'hFFFF, 0, 0, 0);
    adv(65535);
    chk("R13 top value", 32'(count), 32'hFFFF);
    adv(1);
    chk("R13 wrap to zero", {ev_peak, count}, {1'b1, 16'd0});

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule